// File: doc/BRIEF.md
# SPI Register-Access Peripheral with Flow-Control Stall

This block is a SPI peripheral (mode 0, chip select active low) that gives a bus controller byte-wide read and write access to a small register window. Every transaction opens with a four-byte command. The first byte carries the direction and the transfer length. The next three bytes carry a 24-bit bus address, most significant byte first. The peripheral answers each byte in full duplex. In the last bit of every response byte from the fourth one on, it signals whether the controller must keep clocking filler bytes (stall) or may go on with the data phase (release).

SCLK, chip select and MOSI are synchronized to the system clock and oversampled, so SCLK must be several times slower than the system clock. A fixed base address is subtracted from the bus address to form the register offset. Reads wait out a back-end access latency behind the stall and then stream the register bytes back to back. Writes gather their payload in a small circular window. The payload is written into the register array, one byte per system clock, after chip select rises. A byte counter guards the whole transaction. Too many bytes in one selection puts the block into an error state that ignores traffic until chip select rises.

Top module: `spi_reg_periph`

## Requirements
- R1: Command byte 0 selects a read when bit 7 is 1 and a write when it is 0. Bits 5:0 plus one give the length, 1 to 64 bytes. Bytes 1, 2 and 3 are address bits 23:16, 15:8 and 7:0.
- R2: After the command, each response byte in the flow-control phase is exactly 0x00 (stall) or 0x01 (release). Once a 0x01 has been sent, the data phase begins with the very next byte.
- R3: The four response bytes that go out while the command is being received are all 0x00, so bit 0 of the fourth byte always asks for a stall.
- R4: While the back end is busy, stall bytes are sent. The back end is busy for RD_LAT system clocks after a read command completes, and while an earlier write is still being committed. With RD_LAT longer than one SPI byte, a read sees at least one stall byte after the fourth.
- R5: A read returns the bytes at offset, offset+1, and so on. The first of them follows the release byte with no gap. Data-phase bytes past the requested length read as 0xFF.
- R6: The response to every write payload byte is 0x01. On the rise of chip select, the last N payload bytes received after the release byte are written to offset..offset+N-1, where N is the length. If fewer than N payload bytes arrived, nothing is written.
- R7: Offset = bus address − BASE (default 0xD40000), modulo 2^24. Offsets of NREG and above read as 0xFF, and writes to them are dropped. Bytes of the same write that fall inside the window are still written.
- R8: The command, stall, release and write payload bytes of one selection are counted. The byte that would take the count past RX_MAX puts the block in an error state. There every response byte is 0x01, received bytes are ignored and no write is committed.
- R9: A rise of chip select at any point, including mid-command, returns the block to command reception, and the next transaction is decoded from its first byte.
- R10: After reset all registers hold 0x00 and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the controller (idle low) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Controller-to-peripheral data |
| spi_miso | output | 1 | Peripheral-to-controller data, MSB first |

## Verification
The hardest state to reach from the pins is the error state with a write that would otherwise commit. The byte limit has to be crossed on exactly the byte after the limit, with a length the payload fully covers. The bench therefore uses a small RX_MAX. It sends two write lengths that are one byte apart, so that one transaction ends on the limit and the next one crosses it. It computes the expected outcome from the number of stall bytes it actually observed. A read latency longer than one SPI byte forces real stall sequences. A command cut short by chip select checks the return to command reception.

// File: rtl/spi_rpa_pkg.sv
package spi_rpa_pkg;
   typedef enum logic [2:0] {
      ST_HDR,
      ST_WAIT,
      ST_RD,
      ST_WR,
      ST_ERR
   } rpa_st_e;

   localparam logic [7:0] RESP_HOLD = 8'h00;
   localparam logic [7:0] RESP_GO   = 8'h01;
   localparam logic [7:0] RESP_VOID = 8'hFF;
   localparam int         ADDR_W    = 24;
   localparam int         LEN_W     = 7;
   localparam int         MAX_LEN   = 64;
endpackage

// File: rtl/spi_rpa_phy.sv
module spi_rpa_phy (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   input  logic [7:0] tx_byte,
   output logic       miso,
   output logic       tx_load,
   output logic       rx_valid,
   output logic [7:0] rx_byte,
   output logic       cs_fall,
   output logic       cs_rise
);
   logic [2:0] sclk_q;
   logic [2:0] cs_q;
   logic [1:0] mosi_q;
   logic [7:0] tx_sr;
   logic [7:0] rx_sr;
   logic [2:0] bit_cnt;
   logic       active, sck_rise, sck_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= '0;
         cs_q   <= '1;
         mosi_q <= '0;
      end else begin
         sclk_q <= {sclk_q[1:0], sclk};
         cs_q   <= {cs_q[1:0], cs_n};
         mosi_q <= {mosi_q[0], mosi};
      end
   end

   assign active   = ~cs_q[1];
   assign sck_rise = sclk_q[1] & ~sclk_q[2];
   assign sck_fall = ~sclk_q[1] & sclk_q[2];
   assign cs_fall  = ~cs_q[1] & cs_q[2];
   assign cs_rise  = cs_q[1] & ~cs_q[2];
   assign tx_load  = cs_fall | (active & sck_fall & (bit_cnt == 3'd0));
   assign miso     = tx_sr[7];
   assign rx_byte  = rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr    <= '0;
         rx_sr    <= '0;
         bit_cnt  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (tx_load)
            tx_sr <= tx_byte;
         else if (active && sck_fall)
            tx_sr <= {tx_sr[6:0], 1'b0};
         if (!active || cs_fall) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            rx_sr   <= {rx_sr[6:0], mosi_q[1]};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7)
               rx_valid <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_rpa_regs.sv
module spi_rpa_regs
   import spi_rpa_pkg::*;
#(
   parameter int NREG   = 64,
   parameter int RD_LAT = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_start,
   input  logic [ADDR_W-1:0] rd_off,
   output logic [7:0]        rd_data,
   input  logic              wb_we,
   input  logic [7:0]        wb_data,
   input  logic              cm_start,
   input  logic [ADDR_W-1:0] cm_off,
   input  logic [LEN_W-1:0]  cm_cnt,
   output logic              ready
);
   localparam int                IW     = $clog2(NREG);
   localparam int                BW     = $clog2(MAX_LEN);
   localparam logic [ADDR_W-1:0] NREG_L = ADDR_W'(NREG);

   logic [7:0]        mem  [NREG];
   logic [7:0]        wbuf [MAX_LEN];
   logic [BW-1:0]     wptr;
   logic              cm_act;
   logic [LEN_W-1:0]  cm_j, cm_n;
   logic [ADDR_W-1:0] cm_base, cm_tgt;
   logic [BW-1:0]     cm_rd;
   logic              lat_busy;

   always_ff @(posedge clk) begin
      if (wb_we)
         wbuf[wptr] <= wb_data;
   end

   assign cm_tgt  = cm_base + {{(ADDR_W-LEN_W){1'b0}}, cm_j};
   assign rd_data = (rd_off < NREG_L) ? mem[rd_off[IW-1:0]] : RESP_VOID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++)
            mem[i] <= '0;
         wptr    <= '0;
         cm_act  <= 1'b0;
         cm_j    <= '0;
         cm_n    <= '0;
         cm_base <= '0;
         cm_rd   <= '0;
      end else begin
         if (wb_we)
            wptr <= wptr + 1'b1;
         if (cm_start) begin
            cm_act  <= 1'b1;
            cm_j    <= '0;
            cm_n    <= cm_cnt;
            cm_base <= cm_off;
            cm_rd   <= wptr - cm_cnt[BW-1:0];
         end else if (cm_act) begin
            if (cm_tgt < NREG_L)
               mem[cm_tgt[IW-1:0]] <= wbuf[cm_rd];
            cm_rd <= cm_rd + 1'b1;
            cm_j  <= cm_j + 1'b1;
            if (cm_j == cm_n - 1'b1)
               cm_act <= 1'b0;
         end
      end
   end

   generate
      if (RD_LAT == 0) begin : g_nolat
         logic unused_rd_start;
         assign unused_rd_start = rd_start;
         assign lat_busy = 1'b0;
      end else begin : g_lat
         localparam int LW = $clog2(RD_LAT + 1);
         logic [LW-1:0] lat_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lat_cnt <= '0;
            else if (rd_start)
               lat_cnt <= LW'(RD_LAT);
            else if (lat_cnt != '0)
               lat_cnt <= lat_cnt - 1'b1;
         end
         assign lat_busy = (lat_cnt != '0);
      end
   endgenerate

   assign ready = ~lat_busy & ~cm_act;
endmodule

// File: rtl/spi_rpa_ctrl.sv
module spi_rpa_ctrl
   import spi_rpa_pkg::*;
#(
   parameter int                RX_MAX = 512,
   parameter logic [ADDR_W-1:0] BASE   = 24'hD40000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              tx_load,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              ready,
   input  logic [7:0]        rd_data,
   output logic [7:0]        tx_byte,
   output logic              rd_start,
   output logic [ADDR_W-1:0] rd_off,
   output logic              wb_we,
   output logic [7:0]        wb_data,
   output logic              cm_start,
   output logic [ADDR_W-1:0] cm_off,
   output logic [LEN_W-1:0]  cm_cnt,
   output rpa_st_e           st
);
   localparam int            TW     = $clog2(RX_MAX + 1);
   localparam logic [TW-1:0] RX_LIM = TW'(RX_MAX);

   logic [1:0]        hdr_idx;
   logic              is_rd;
   logic [LEN_W-1:0]  len;
   logic [ADDR_W-1:0] addr, off;
   logic [TW-1:0]     tot;
   logic              skip_rel;
   logic [LEN_W-1:0]  rd_i, wr_got;
   logic              counted, over;

   assign off      = addr - BASE;
   assign rd_off   = off + {{(ADDR_W-LEN_W){1'b0}}, rd_i};
   assign cm_off   = off;
   assign cm_cnt   = len;
   assign counted  = (st == ST_HDR) || (st == ST_WAIT) || (st == ST_WR);
   assign over     = rx_valid && counted && (tot == RX_LIM);
   assign rd_start = rx_valid && !over && (st == ST_HDR) && (hdr_idx == 2'd3) && is_rd;
   assign wb_we    = rx_valid && !over && (st == ST_WR) && !skip_rel;
   assign wb_data  = rx_byte;
   assign cm_start = cs_rise && (st == ST_WR) && (wr_got == len);

   always_comb begin
      unique case (st)
         ST_HDR:  tx_byte = RESP_HOLD;
         ST_WAIT: tx_byte = ready ? RESP_GO : RESP_HOLD;
         ST_RD:   tx_byte = (rd_i != len) ? rd_data : RESP_VOID;
         default: tx_byte = RESP_GO;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_HDR;
         hdr_idx  <= '0;
         is_rd    <= 1'b0;
         len      <= '0;
         addr     <= '0;
         tot      <= '0;
         skip_rel <= 1'b0;
         rd_i     <= '0;
         wr_got   <= '0;
      end else if (cs_rise || cs_fall) begin
         st       <= ST_HDR;
         hdr_idx  <= '0;
         tot      <= '0;
         skip_rel <= 1'b0;
         rd_i     <= '0;
         wr_got   <= '0;
      end else if (rx_valid) begin
         if (over) begin
            st <= ST_ERR;
         end else begin
            if (counted)
               tot <= tot + 1'b1;
            unique case (st)
               ST_HDR: begin
                  if (hdr_idx == 2'd0) begin
                     is_rd <= rx_byte[7];
                     len   <= {1'b0, rx_byte[5:0]} + 1'b1;
                  end else begin
                     addr <= {addr[15:0], rx_byte};
                  end
                  hdr_idx <= hdr_idx + 1'b1;
                  if (hdr_idx == 2'd3)
                     st <= ST_WAIT;
               end
               ST_RD: skip_rel <= 1'b0;
               ST_WR: begin
                  if (skip_rel)
                     skip_rel <= 1'b0;
                  else if (wr_got != len)
                     wr_got <= wr_got + 1'b1;
               end
               default: ;
            endcase
         end
      end else if (tx_load) begin
         if (st == ST_WAIT && ready) begin
            st       <= is_rd ? ST_RD : ST_WR;
            skip_rel <= 1'b1;
         end else if (st == ST_RD && rd_i != len) begin
            rd_i <= rd_i + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_reg_periph.sv
module spi_reg_periph
   import spi_rpa_pkg::*;
#(
   parameter int                NREG   = 64,
   parameter int                RX_MAX = 512,
   parameter int                RD_LAT = 100,
   parameter logic [ADDR_W-1:0] BASE   = 24'hD40000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sclk,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);
   generate
      if (NREG < 2 || NREG > 4096) begin : g_bad_nreg
         $error("NREG must lie in 2..4096");
      end
      if (RX_MAX < 8 || RX_MAX > 65535) begin : g_bad_rxmax
         $error("RX_MAX must lie in 8..65535");
      end
      if (RD_LAT < 0 || RD_LAT > 1048575) begin : g_bad_lat
         $error("RD_LAT must lie in 0..1048575");
      end
   endgenerate

   logic              tx_load, rx_valid, cs_fall, cs_rise;
   logic [7:0]        rx_byte, tx_byte, rd_data, wb_data;
   logic              rd_start, wb_we, cm_start, ready;
   logic [ADDR_W-1:0] rd_off, cm_off;
   logic [LEN_W-1:0]  cm_cnt;
   rpa_st_e           st;

   spi_rpa_phy u_phy (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (spi_sclk),
      .cs_n     (spi_cs_n),
      .mosi     (spi_mosi),
      .tx_byte  (tx_byte),
      .miso     (spi_miso),
      .tx_load  (tx_load),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .cs_fall  (cs_fall),
      .cs_rise  (cs_rise)
   );

   spi_rpa_ctrl #(.RX_MAX(RX_MAX), .BASE(BASE)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .tx_load  (tx_load),
      .cs_fall  (cs_fall),
      .cs_rise  (cs_rise),
      .ready    (ready),
      .rd_data  (rd_data),
      .tx_byte  (tx_byte),
      .rd_start (rd_start),
      .rd_off   (rd_off),
      .wb_we    (wb_we),
      .wb_data  (wb_data),
      .cm_start (cm_start),
      .cm_off   (cm_off),
      .cm_cnt   (cm_cnt),
      .st       (st)
   );

   spi_rpa_regs #(.NREG(NREG), .RD_LAT(RD_LAT)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_start (rd_start),
      .rd_off   (rd_off),
      .rd_data  (rd_data),
      .wb_we    (wb_we),
      .wb_data  (wb_data),
      .cm_start (cm_start),
      .cm_off   (cm_off),
      .cm_cnt   (cm_cnt),
      .ready    (ready)
   );
endmodule

// File: rtl/spi_reg_periph_chk.sv
module spi_reg_periph_chk
   import spi_rpa_pkg::*;
(
   input logic    clk,
   input logic    rst_n,
   input rpa_st_e st,
   input logic    tx_load,
   input logic    ready,
   input logic    cs_rise,
   input logic    cs_fall,
   input logic    cm_start,
   input logic    miso
);
   a_r3_hdr_miso_low: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && st == ST_HDR) |=> !miso);

   a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && tx_load && !ready && !cs_rise) |=> st == ST_WAIT);

   a_r2_release_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && tx_load && ready && !cs_fall) |=> (st == ST_RD || st == ST_WR));

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERR && !cs_rise && !cs_fall) |=> st == ST_ERR);

   a_r8_err_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERR) |-> !cm_start);

   a_r9_cs_rise_hdr: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> st == ST_HDR);

   a_r6_commit_at_cs: assert property (@(posedge clk) disable iff (!rst_n)
      cm_start |-> cs_rise);
endmodule

bind spi_reg_periph spi_reg_periph_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .st       (st),
   .tx_load  (tx_load),
   .ready    (ready),
   .cs_rise  (cs_rise),
   .cs_fall  (cs_fall),
   .cm_start (cm_start),
   .miso     (spi_miso)
);

// File: tb/sim_spi_reg_periph.sv
module sim_spi_reg_periph;
   localparam int          NREG   = 16;
   localparam int          RX_MAX = 40;
   localparam int          RD_LAT = 150;
   localparam logic [23:0] BASE   = 24'hD40000;
   localparam int          HALF   = 6;
   localparam int          GAP    = 90;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic mosi = 1'b0;
   logic miso;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [7:0] model [NREG];

   always #5 clk = ~clk;

   spi_reg_periph #(.NREG(NREG), .RX_MAX(RX_MAX), .RD_LAT(RD_LAT), .BASE(BASE)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sclk (sclk),
      .spi_cs_n (cs_n),
      .spi_mosi (mosi),
      .spi_miso (miso)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [23:0] o);
      return (o < 24'(NREG)) ? model[o[3:0]] : 8'hFF;
   endfunction

   task automatic xfer(input logic [7:0] o, output logic [7:0] r);
      for (int b = 7; b >= 0; b--) begin
         mosi = o[b];
         repeat (HALF) @(posedge clk);
         #1 r[b] = miso;
         sclk = 1'b1;
         repeat (HALF) @(posedge clk);
         #1 sclk = 1'b0;
      end
   endtask

   task automatic cs_lo();
      @(posedge clk);
      #1 cs_n = 1'b0;
   endtask

   task automatic cs_hi();
      repeat (HALF) @(posedge clk);
      #1 cs_n = 1'b1;
      repeat (GAP) @(posedge clk);
      #1;
   endtask

   // Command bytes, then poll until release; returns the number of stall bytes.
   task automatic command(input bit rd, input int len, input logic [23:0] addr, output int stalls);
      logic [7:0] r;
      logic [7:0] hb [4];
      bit rel = 1'b0;
      hb[0] = {rd, 1'b0, 6'(len - 1)};
      hb[1] = addr[23:16];
      hb[2] = addr[15:8];
      hb[3] = addr[7:0];
      stalls = 0;
      for (int k = 0; k < 4; k++) begin
         xfer(hb[k], r);
         chk("R3 command-phase response", r, 8'h00);
      end
      for (int k = 0; k < 10 && !rel; k++) begin
         xfer(8'h00, r);
         if (r == 8'h01) rel = 1'b1;
         else begin
            chk("R2 stall byte value", r, 8'h00);
            stalls++;
         end
      end
      chk("R2 release seen", {7'b0, rel}, 8'h01);
   endtask

   task automatic do_write(input logic [23:0] addr, input int len, input int nsend, input logic [7:0] seed);
      logic [7:0] r;
      int s;
      logic [23:0] o;
      cs_lo();
      command(1'b0, len, addr, s);
      for (int i = 0; i < nsend; i++) begin
         xfer(seed + 8'(i), r);
         chk("R6 payload response", r, 8'h01);
      end
      cs_hi();
      if ((5 + s + nsend) <= RX_MAX && nsend >= len) begin
         for (int i = 0; i < len; i++) begin
            o = addr - BASE + 24'(i);
            if (o < 24'(NREG)) model[o[3:0]] = seed + 8'(nsend - len + i);
         end
      end
   endtask

   task automatic do_read(input logic [23:0] addr, input int len, input int nclk, input string tag);
      logic [7:0] r;
      int s;
      logic [23:0] o;
      cs_lo();
      command(1'b1, len, addr, s);
      chk("R4 read stalls while back end busy", {7'b0, s >= 1}, 8'h01);
      for (int i = 0; i < nclk; i++) begin
         xfer(8'h00, r);
         o = addr - BASE + 24'(i);
         if (i < len) chk(tag, r, exp_rd(o));
         else chk("R5 byte past length", r, 8'hFF);
      end
      cs_hi();
   endtask

   initial begin
      int cycles = 0;
      while (!done && cycles < 190000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=<190000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      int lens [3];
      lens[0] = 1; lens[1] = 3; lens[2] = 7;
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1 chk("R10 miso low after reset", {7'b0, miso}, 8'h00);
      do_read(BASE, NREG, NREG, "R10 reset contents");

      // R1 and R5: sweep offsets and lengths, write then read back with one extra byte
      for (int off = 0; off < NREG; off += 3) begin
         for (int k = 0; k < 3; k++) begin
            do_write(BASE + 24'(off), lens[k], lens[k], 8'(off * 16 + lens[k]));
            do_read(BASE + 24'(off), lens[k], lens[k] + 1, "R1 readback");
         end
      end

      // R7: window edge, foreign address, wrapped offset
      do_write(BASE + 24'd14, 4, 4, 8'hA0);
      do_read(BASE + 24'd12, 8, 8, "R7 window edge");
      do_write(24'h000003, 2, 2, 8'h55);
      do_read(BASE, NREG, NREG, "R7 foreign write dropped");
      do_read(24'hD3FFFF, 2, 2, "R7 wrapped offset reads FF");

      // R6: extra payload keeps the last bytes; short payload commits nothing
      do_write(BASE + 24'd2, 2, 5, 8'h30);
      do_read(BASE, 8, 8, "R6 last bytes kept");
      do_write(BASE + 24'd4, 4, 2, 8'h70);
      do_read(BASE, 8, 8, "R6 short payload dropped");

      // R8: one write ends on the byte limit, the next crosses it
      do_write(BASE, 35, 35, 8'h10);
      do_read(BASE, NREG, NREG, "R8 write at limit commits");
      do_write(BASE, 36, 36, 8'hC0);
      do_read(BASE, NREG, NREG, "R8 overflowed write dropped");

      // R9: command cut short by chip select
      cs_lo();
      xfer(8'h83, r);
      chk("R9 aborted command response", r, 8'h00);
      xfer(8'hD4, r);
      cs_hi();
      do_read(BASE + 24'd1, 4, 4, "R9 fresh decode after abort");

      // R1: maximum length field
      do_read(BASE, 64, 64, "R1 max length read");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule